// File: doc/BRIEF.md
# Segmented Data Access Unit

This block turns a 16-bit data offset and a segment base into 20-bit physical byte transactions on a byte-wide memory port. It serves byte and word loads and stores for a datapath that holds four segment base registers. The four bases are the code, data, extra and stack segments.

The segment comes from one of three places. A single active override prefix wins. With no override, the base is the data segment, or the stack segment when the addressing mode asks for it. In absolute mode the base comes straight from a request input. A word access becomes two byte transactions, low byte first. The high byte's offset wraps inside the 64 KiB segment before the base is added, and every physical address wraps at 1 MiB.

The unit takes one request at a time. It reports completion with a one-cycle done pulse, or with a one-cycle error pulse when more than one override is active.

Top module: `seg_access_unit`

## Requirements
- R1: The physical address is (segment × 16 + effective offset) modulo 2^20, so accesses above 1 MiB wrap to the bottom of memory.
- R2: With no override bit set and absolute mode off, the base is `seg_ds`. When `dflt_stack` is 1, the base is `seg_ss` instead.
- R3: Override bits are encoded as bit 0 = code, bit 1 = data, bit 2 = extra, bit 3 = stack. Exactly one set bit selects that base, whatever `dflt_stack` is.
- R4: With absolute mode off and two or more override bits set, no memory transaction is issued, `done` stays low, and `err` is high for exactly one cycle: the cycle after acceptance.
- R5: A word access issues two transactions, low byte then high byte. The high byte uses offset (offset + 1) modulo 2^16. Each transaction holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack` is sampled high.
- R6: A word write sends `req_wdata[7:0]` in the low-byte transaction and `req_wdata[15:8]` in the high-byte transaction.
- R7: In absolute mode the base is `req_seg_abs`. The override bits have no effect, even when several are set.
- R8: `done` is high for one cycle, directly after the final byte's acknowledge. On a read, `rd_data` then shows {high byte, low byte}, or {8'h00, byte} for a byte read. `rd_data` holds that value until the next read completes, and writes leave it unchanged.
- R9: A request is accepted only in a cycle where `busy` is low. `busy` (and `mem_req`) is high from the cycle after acceptance until the final acknowledge. Requests made while busy have no effect.
- R10: After reset, `busy`, `mem_req`, `done`, `err` and `rd_data` are all zero.
- R11: The segment bases, offset and write data are captured at acceptance. Changing those inputs during the operation does not change its transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_abs | input | 1 | Absolute mode: base from `req_seg_abs` |
| req_offset | input | 16 | Data offset within the segment |
| req_wdata | input | 16 | Store data (low byte used for byte stores) |
| req_seg_abs | input | 16 | Explicit base for absolute mode |
| seg_cs | input | 16 | Code segment base |
| seg_ds | input | 16 | Data segment base |
| seg_es | input | 16 | Extra segment base |
| seg_ss | input | 16 | Stack segment base |
| ovr_sel | input | 4 | Override bits: [0] code, [1] data, [2] extra, [3] stack |
| dflt_stack | input | 1 | Default base is stack instead of data |
| mem_req | output | 1 | Byte transaction valid |
| mem_we | output | 1 | Byte transaction is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte write data |
| mem_ack | input | 1 | Transaction accepted/completed this cycle |
| mem_rdata | input | 8 | Byte read data, valid with `mem_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle multiple-override error pulse |
| rd_data | output | 16 | Result of the last completed read |

## Verification
Two events can fall in the same cycle: the completion of one operation and the acceptance of the next. A request held high while the unit is busy is taken in the very cycle `done` pulses. The bench provokes this by holding `req_valid` across the end of a slow, multi-cycle word read. In the same window it changes the segment bases. The behavioural model predicts the outcome on every clock: the queue of expected byte transactions, `busy`, `done`, `err` and `rd_data`. It judges that the held request is ignored while busy, accepted exactly once afterwards, and that the first operation's addresses still use the bases captured at its own acceptance.

// File: rtl/seg_access_pkg.sv
package seg_access_pkg;

  // Number of segment base registers and their slot order (matches ovr_sel bits)
  localparam int NUM_SEG = 4;
  localparam int IDX_CODE  = 0;
  localparam int IDX_DATA  = 1;
  localparam int IDX_EXTRA = 2;
  localparam int IDX_STACK = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } acc_state_e;

endpackage

// File: rtl/seg_base_select.sv
module seg_base_select
  import seg_access_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [NUM_SEG-1:0][SEG_W-1:0] bank,
  input  logic [NUM_SEG-1:0]            ovr,
  input  logic                          dflt_stack,
  input  logic                          abs_mode,
  input  logic [SEG_W-1:0]              seg_abs,
  output logic [SEG_W-1:0]              base,
  output logic                          multi_ovr
);

  localparam int CNT_W = $clog2(NUM_SEG + 1);

  logic [NUM_SEG-1:0][SEG_W-1:0] masked;
  logic [SEG_W-1:0]              ovr_base;
  logic [CNT_W-1:0]              n_ovr;

  // AND-OR mux: each bank entry gated by its override bit
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_mask
    assign masked[g] = {SEG_W{ovr[g]}} & bank[g];
  end

  always_comb begin
    ovr_base = '0;
    n_ovr    = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      ovr_base = ovr_base | masked[i];
      n_ovr    = n_ovr + {{(CNT_W-1){1'b0}}, ovr[i]};
    end
  end

  always_comb begin
    if (abs_mode) begin
      base = seg_abs;
    end else if (n_ovr == '0) begin
      base = dflt_stack ? bank[IDX_STACK] : bank[IDX_DATA];
    end else begin
      base = ovr_base;
    end
  end

  assign multi_ovr = !abs_mode && (n_ovr > CNT_W'(1));

endmodule

// File: rtl/phys_addr_gen.sv
module phys_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = 20
) (
  input  logic [SEG_W-1:0]  base,
  input  logic [OFF_W-1:0]  offset,
  input  logic              second_byte,
  output logic [PHYS_W-1:0] phys
);

  localparam int SHIFTED_W = SEG_W + SEG_SHIFT;
  localparam int SUM_W     = ((SHIFTED_W > OFF_W) ? SHIFTED_W : OFF_W) + 1;

  logic [OFF_W-1:0] off_eff;
  logic [SUM_W-1:0] sum;

  // Offset increment wraps inside the segment before the base is added
  assign off_eff = offset + {{(OFF_W-1){1'b0}}, second_byte};
  assign sum     = SUM_W'({base, {SEG_SHIFT{1'b0}}}) + SUM_W'(off_eff);
  // Truncation gives the wrap at the top of physical memory
  assign phys    = sum[PHYS_W-1:0];

endmodule

// File: rtl/access_sequencer.sv
module access_sequencer
  import seg_access_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [2*BYTE_W-1:0] req_wdata,
  input  logic [SEG_W-1:0]    sel_base,
  input  logic                sel_err,
  input  logic                mem_ack,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [SEG_W-1:0]    cur_base,
  output logic [OFF_W-1:0]    cur_offset,
  output logic                second_byte,
  output logic                mem_req,
  output logic                mem_we,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [2*BYTE_W-1:0] rd_data
);

  localparam int WORD_W = 2 * BYTE_W;

  acc_state_e state_q, state_n;

  logic [SEG_W-1:0]  base_q;
  logic [OFF_W-1:0]  off_q;
  logic [WORD_W-1:0] wdata_q;
  logic              we_q;
  logic              word_q;
  logic [BYTE_W-1:0] lo_q;
  logic [WORD_W-1:0] rd_q, rd_n;
  logic              done_q, done_n;
  logic              err_q, err_n;

  logic load_en;
  logic lo_cap_en;
  logic rd_en;

  // Next-state and enables
  always_comb begin
    state_n   = state_q;
    done_n    = 1'b0;
    err_n     = 1'b0;
    load_en   = 1'b0;
    lo_cap_en = 1'b0;
    rd_en     = 1'b0;
    rd_n      = rd_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (sel_err) begin
            err_n = 1'b1;
          end else begin
            load_en = 1'b1;
            state_n = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (mem_ack) begin
          if (word_q) begin
            lo_cap_en = !we_q;
            state_n   = ST_HIGH;
          end else begin
            done_n  = 1'b1;
            state_n = ST_IDLE;
            rd_en   = !we_q;
            rd_n    = {{BYTE_W{1'b0}}, mem_rdata};
          end
        end
      end
      ST_HIGH: begin
        if (mem_ack) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
          rd_en   = !we_q;
          rd_n    = {mem_rdata, lo_q};
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  // Request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      off_q   <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
    end else if (load_en) begin
      base_q  <= sel_base;
      off_q   <= req_offset;
      wdata_q <= req_wdata;
      we_q    <= req_write;
      word_q  <= req_word;
    end
  end

  // Low byte of a word read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_cap_en) begin
      lo_q <= mem_rdata;
    end
  end

  // Read result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_n;
    end
  end

  assign cur_base    = base_q;
  assign cur_offset  = off_q;
  assign second_byte = (state_q == ST_HIGH);
  assign mem_req     = (state_q != ST_IDLE);
  assign busy        = (state_q != ST_IDLE);
  assign mem_we      = we_q;
  assign mem_wdata   = second_byte ? wdata_q[WORD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
  assign done        = done_q;
  assign err         = err_q;
  assign rd_data     = rd_q;

endmodule

// File: rtl/seg_access_unit.sv
module seg_access_unit
  import seg_access_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = 20,
  parameter int BYTE_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic                req_abs,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [2*BYTE_W-1:0] req_wdata,
  input  logic [SEG_W-1:0]    req_seg_abs,
  input  logic [SEG_W-1:0]    seg_cs,
  input  logic [SEG_W-1:0]    seg_ds,
  input  logic [SEG_W-1:0]    seg_es,
  input  logic [SEG_W-1:0]    seg_ss,
  input  logic [NUM_SEG-1:0]  ovr_sel,
  input  logic                dflt_stack,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PHYS_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [2*BYTE_W-1:0] rd_data
);

  logic [NUM_SEG-1:0][SEG_W-1:0] bank;
  logic [SEG_W-1:0]              sel_base;
  logic                          sel_err;
  logic [SEG_W-1:0]              cur_base;
  logic [OFF_W-1:0]              cur_offset;
  logic                          second_byte;

  assign bank[IDX_CODE]  = seg_cs;
  assign bank[IDX_DATA]  = seg_ds;
  assign bank[IDX_EXTRA] = seg_es;
  assign bank[IDX_STACK] = seg_ss;

  seg_base_select #(
    .SEG_W (SEG_W)
  ) u_select (
    .bank       (bank),
    .ovr        (ovr_sel),
    .dflt_stack (dflt_stack),
    .abs_mode   (req_abs),
    .seg_abs    (req_seg_abs),
    .base       (sel_base),
    .multi_ovr  (sel_err)
  );

  access_sequencer #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .BYTE_W (BYTE_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_word    (req_word),
    .req_offset  (req_offset),
    .req_wdata   (req_wdata),
    .sel_base    (sel_base),
    .sel_err     (sel_err),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .cur_base    (cur_base),
    .cur_offset  (cur_offset),
    .second_byte (second_byte),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .rd_data     (rd_data)
  );

  phys_addr_gen #(
    .SEG_W     (SEG_W),
    .OFF_W     (OFF_W),
    .SEG_SHIFT (SEG_SHIFT),
    .PHYS_W    (PHYS_W)
  ) u_addr (
    .base        (cur_base),
    .offset      (cur_offset),
    .second_byte (second_byte),
    .phys        (mem_addr)
  );

endmodule

// File: rtl/seg_access_checks.sv
module seg_access_checks #(
  parameter int PHYS_W = 20,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [PHYS_W-1:0] mem_addr,
  input logic [BYTE_W-1:0] mem_wdata
);

  // R9: no memory traffic outside an accepted operation
  assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R9: an operation starts only from a presented request
  assert_start_from_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R5: a transaction is held until acknowledged
  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8: done is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done only follows an acknowledged transaction
  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ack));

  // R4: an error never coincides with completion or memory traffic
  assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !mem_req));

  // R4: error is a single-cycle pulse
  assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

endmodule

bind seg_access_unit seg_access_checks #(
  .PHYS_W (PHYS_W),
  .BYTE_W (BYTE_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/seg_access_unit_tb_top.sv
module seg_access_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_word, req_abs;
  logic [15:0] req_offset, req_wdata, req_seg_abs;
  logic [15:0] seg_cs, seg_ds, seg_es, seg_ss;
  logic [3:0]  ovr_sel;
  logic        dflt_stack;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack;
  logic [7:0]  mem_rdata;
  logic        busy, done, err;
  logic [15:0] rd_data;

  seg_access_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word), .req_abs(req_abs),
    .req_offset(req_offset), .req_wdata(req_wdata), .req_seg_abs(req_seg_abs),
    .seg_cs(seg_cs), .seg_ds(seg_ds), .seg_es(seg_es), .seg_ss(seg_ss),
    .ovr_sel(ovr_sel), .dflt_stack(dflt_stack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- bench memory ----------------
  logic [7:0] mem [int];
  int ack_lat = 0;
  int wcnt = 0;

  function automatic logic [7:0] mem_rd(input int a);
    logic [31:0] av;
    av = a;
    if (mem.exists(a)) return mem[a];
    return av[7:0] ^ av[15:8] ^ 8'hA5;
  endfunction

  initial begin
    mem_ack = 1'b0;
    mem_rdata = 8'h00;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && mem_req) begin
        if (wcnt >= ack_lat) begin
          mem_ack = 1'b1;
          mem_rdata = mem_rd(int'(mem_addr));
          if (mem_we) mem[int'(mem_addr)] = mem_wdata;
          wcnt = 0;
        end else begin
          mem_ack = 1'b0;
          mem_rdata = 8'hXX;
          wcnt++;
        end
      end else begin
        mem_ack = 1'b0;
        wcnt = 0;
      end
    end
  end

  // ---------------- reference model ----------------
  int         q_addr[$];
  bit         q_we[$];
  logic [7:0] q_wd[$];
  bit         exp_done = 0;
  bit         exp_err = 0;
  logic [15:0] exp_rd = 16'h0;
  logic [15:0] pend_rd;
  bit         pend_we;
  int         n_acc = 0;

  function automatic int phys(input int seg, input int off);
    return ((seg << 4) + (off & 32'hFFFF)) & 32'hFFFFF;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      q_addr.delete(); q_we.delete(); q_wd.delete();
      exp_done = 0; exp_err = 0; exp_rd = 16'h0;
    end else begin
      bit idle_now;
      idle_now = (q_addr.size() == 0);
      // compare outputs against the prediction
      check(busy == !idle_now, "R9 busy", busy, !idle_now);
      check(mem_req == !idle_now, "R9 mem_req", mem_req, !idle_now);
      check(done == exp_done, "R8 done", done, exp_done);
      check(err == exp_err, "R4 err", err, exp_err);
      check(rd_data == exp_rd, "R8 rd_data", rd_data, exp_rd);
      exp_done = 0;
      exp_err = 0;
      if (mem_req && mem_ack && !idle_now) begin
        check(int'(mem_addr) == q_addr[0], "R1 R5 mem_addr", mem_addr, q_addr[0]);
        check(mem_we == q_we[0], "R5 mem_we", mem_we, q_we[0]);
        if (q_we[0]) check(mem_wdata == q_wd[0], "R6 mem_wdata", mem_wdata, q_wd[0]);
        void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_wd.pop_front());
        if (q_addr.size() == 0) begin
          exp_done = 1;
          if (!pend_we) exp_rd = pend_rd;
        end
      end
      // acceptance of a new request
      if (req_valid && idle_now) begin
        int seg;
        int nov;
        int a0;
        int a1;
        n_acc++;
        nov = 0;
        for (int i = 0; i < 4; i++) nov += ovr_sel[i];
        if (req_abs)             seg = req_seg_abs;
        else if (nov == 0)       seg = dflt_stack ? seg_ss : seg_ds;
        else if (ovr_sel == 4'b0001) seg = seg_cs;
        else if (ovr_sel == 4'b0010) seg = seg_ds;
        else if (ovr_sel == 4'b0100) seg = seg_es;
        else                     seg = seg_ss;
        if (!req_abs && nov > 1) begin
          exp_err = 1;
        end else begin
          a0 = phys(seg, req_offset);
          a1 = phys(seg, req_offset + 1);
          pend_we = req_write;
          q_addr.push_back(a0); q_we.push_back(req_write); q_wd.push_back(req_wdata[7:0]);
          if (req_word) begin
            q_addr.push_back(a1); q_we.push_back(req_write); q_wd.push_back(req_wdata[15:8]);
            pend_rd = {mem_rd(a1), mem_rd(a0)};
          end else begin
            pend_rd = {8'h00, mem_rd(a0)};
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle();
    do begin
      @(negedge clk); #1;
    end while (q_addr.size() != 0 || exp_done || exp_err);
  endtask

  task automatic issue(input bit wr, input bit wd, input bit ab, input logic [15:0] off,
                       input logic [15:0] wdat, input logic [15:0] sabs,
                       input logic [3:0] ovr, input bit dss);
    wait_idle();
    @(posedge clk); #2;
    req_write = wr; req_word = wd; req_abs = ab; req_offset = off;
    req_wdata = wdat; req_seg_abs = sabs; ovr_sel = ovr; dflt_stack = dss;
    req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_word = 0; req_abs = 0;
    req_offset = 0; req_wdata = 0; req_seg_abs = 0;
    seg_cs = 16'h1000; seg_ds = 16'h2000; seg_es = 16'h3000; seg_ss = 16'h4000;
    ovr_sel = 0; dflt_stack = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    check(!busy && !mem_req && !done && !err && rd_data == 16'h0, "R10 reset", {busy, mem_req, done, err}, 0);

    // R2 default data segment, byte read
    issue(0, 0, 0, 16'h0123, 0, 0, 4'b0000, 0);
    // R2 default stack segment
    issue(0, 0, 0, 16'h0456, 0, 0, 4'b0000, 1);
    // R3 extra override beats stack default; R5 word read
    issue(0, 1, 0, 16'h0010, 0, 0, 4'b0100, 1);
    // R3 each single override, byte writes
    issue(1, 0, 0, 16'h0020, 16'h00C1, 0, 4'b0001, 1);
    issue(1, 0, 0, 16'h0021, 16'h00D2, 0, 4'b0010, 1);
    issue(1, 0, 0, 16'h0022, 16'h00E3, 0, 4'b1000, 0);
    // R6 word write with slow acknowledge
    ack_lat = 2;
    issue(1, 1, 0, 16'h0100, 16'hBEEF, 0, 4'b0000, 0);
    // R8 read back the word just written
    issue(0, 1, 0, 16'h0100, 0, 0, 4'b0000, 0);
    ack_lat = 0;
    // R1 wrap at 1 MiB
    seg_ds = 16'hFFFF;
    issue(1, 1, 0, 16'hFFF0, 16'h1234, 0, 4'b0000, 0);
    issue(0, 1, 0, 16'hFFF0, 0, 0, 4'b0000, 0);
    // R5 offset wrap inside the segment
    seg_ds = 16'h2000;
    issue(0, 1, 0, 16'hFFFF, 0, 0, 4'b0000, 0);
    issue(1, 1, 0, 16'hFFFF, 16'hA55A, 0, 4'b0010, 0);
    // R4 multiple overrides
    issue(0, 1, 0, 16'h0040, 0, 0, 4'b0011, 0);
    issue(1, 0, 0, 16'h0041, 16'h0077, 0, 4'b1100, 1);
    // R7 absolute mode ignores overrides, even several
    issue(1, 1, 1, 16'h0300, 16'hCAFE, 16'h5000, 4'b1111, 1);
    issue(0, 1, 1, 16'h0300, 0, 16'h5000, 4'b0100, 0);
    issue(0, 0, 1, 16'hFFFF, 0, 16'hFFFF, 4'b0000, 1);
    // R9 R11: request held while busy and bases changed mid-operation
    ack_lat = 3;
    issue(0, 1, 0, 16'h0500, 0, 0, 4'b0000, 0);
    begin
      int acc0;
      acc0 = n_acc;
      req_write = 1; req_word = 0; req_offset = 16'h0600; req_wdata = 16'h0099;
      req_valid = 1'b1;
      seg_ds = 16'h7000; seg_ss = 16'h7100;
      do begin
        @(negedge clk); #1;
      end while (n_acc == acc0);
      @(posedge clk); #2;
      req_valid = 1'b0;
      check(n_acc == acc0 + 1, "R9 single accept", n_acc, acc0 + 1);
    end
    ack_lat = 1;
    // R11 follow-up read from the new data base
    issue(0, 1, 0, 16'h0600, 0, 0, 4'b0000, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule